// File: doc/BRIEF.md
# Transfer Completion Interrupt Aggregator

This block gathers the one-cycle event pulses that schedule processing produces and turns them into two sticky status flags. The transfer flag records that a descriptor marked for interrupt-on-completion has finished, that a short packet arrived on an IN of a queue-type transfer, or that a transfer ended in error. The error flag records error completions and transaction errors such as babble. Software clears either flag by writing a one to its position.

The hardware interrupt line is not raised as soon as a flag sets. It is raised only at the next threshold boundary, and only when that flag's enable is one. The boundary is produced inside the block by a counter of micro-frame ticks. It fires once every 2^k micro-frames, where software selects k from 0 to 6. After the line rises, it stays high for as long as any enabled flag remains set.

Top module: `xfer_irq_agg`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, both status flags read 0 and the interrupt line is low.
- R2: A pulse on `ev_ioc_done` sets status bit 0 (the transfer flag) from the next cycle onward.
- R3: A pulse on `ev_short_in` sets status bit 0 from the next cycle onward.
- R4: A pulse on `ev_err_done` sets both status bit 0 and status bit 1 (the error flag) from the next cycle onward.
- R5: A pulse on `ev_xact_err` sets status bit 1 from the next cycle onward and leaves bit 0 unchanged.
- R6: A set flag stays set until `sts_clr_we` is high with a one in that flag's position of `sts_clr_mask`. The flag then reads 0 from the next cycle. A zero in the mask leaves that flag unchanged.
- R7: When a setting event and a clear of the same flag fall in one cycle, the flag reads 1 afterwards.
- R8: A threshold boundary occurs on every 2^k-th `uf_tick` counted from reset or from the previous boundary, where k is the value of `thr_sel`. Any value above 6 counts as 6.
- R9: `irq_o` can rise only in the cycle after a boundary. It rises if, in the boundary cycle, some status flag is already set and has its `irq_en` bit at 1. An event that arrives in the boundary cycle itself waits for the next boundary.
- R10: A flag whose `irq_en` bit is 0 never raises `irq_o`.
- R11: Once `irq_o` is high, it stays high while any enabled flag is set. It goes low in the cycle after the last such flag is cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_tick | input | 1 | One-cycle pulse at each micro-frame start |
| thr_sel | input | SEL_W | Threshold exponent k (boundary every 2^k micro-frames) |
| ev_ioc_done | input | 1 | Descriptor with interrupt-on-completion finished |
| ev_short_in | input | 1 | Short packet received on an IN |
| ev_err_done | input | 1 | Transfer completed because of errors |
| ev_xact_err | input | 1 | Babble or other transaction error |
| irq_en | input | 2 | Per-flag interrupt enables (bit 0 transfer, bit 1 error) |
| sts_clr_we | input | 1 | Write strobe for write-one-to-clear |
| sts_clr_mask | input | 2 | Flags to clear when the strobe is high |
| irq_sts | output | 2 | Sticky flags (bit 0 transfer, bit 1 error) |
| irq_o | output | 1 | Hardware interrupt line |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a setting event and a write-one-to-clear of the same flag. The second pair is an event and a threshold boundary. The bench provokes both collisions on purpose: it pulses an event in the same cycle as the clear strobe, and it places an event on the `uf_tick` that completes the count. In each case the bench predicts from the requirements that the flag survives the clear, and that the interrupt waits for the following boundary. It then compares flags and line in every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int STS_N    = 2;
   localparam int IDX_XFER = 0;
   localparam int IDX_ERR  = 1;
   typedef logic [STS_N-1:0] sts_vec_t;
endpackage

// File: rtl/irq_thr_timer.sv
module irq_thr_timer #(
   parameter int SEL_W    = 3,
   parameter int MAX_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uf_tick,
   input  logic [SEL_W-1:0] thr_sel,
   output logic             thr_hit
);
   localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   int               eff_sel;

   always_comb begin
      eff_sel = (int'(thr_sel) > MAX_LOG2) ? MAX_LOG2 : int'(thr_sel);
      lim     = CNT_W'((1 << eff_sel) - 1);
   end

   assign thr_hit = uf_tick && (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (thr_hit) cnt_q <= '0;
      else if (uf_tick) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/irq_sts_bit.sv
module irq_sts_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate
   import irq_agg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     thr_hit,
   input  sts_vec_t sts,
   input  sts_vec_t en,
   output logic     irq_o
);
   logic pend;
   assign pend = |(sts & en);

   always_ff @(posedge clk) begin
      if (!rst_n)       irq_o <= 1'b0;
      else if (thr_hit) irq_o <= pend;
      else              irq_o <= irq_o & pend;
   end
endmodule

// File: rtl/xfer_irq_agg.sv
module xfer_irq_agg
   import irq_agg_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int MAX_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uf_tick,
   input  logic [SEL_W-1:0] thr_sel,
   input  logic             ev_ioc_done,
   input  logic             ev_short_in,
   input  logic             ev_err_done,
   input  logic             ev_xact_err,
   input  logic [1:0]       irq_en,
   input  logic             sts_clr_we,
   input  logic [1:0]       sts_clr_mask,
   output logic [1:0]       irq_sts,
   output logic             irq_o
);
   if (MAX_LOG2 < 1 || MAX_LOG2 > 15) begin : g_bad_log2
      $error("MAX_LOG2 out of range");
   end
   if ((1 << SEL_W) <= MAX_LOG2) begin : g_bad_sel
      $error("SEL_W too narrow for MAX_LOG2");
   end

   logic     thr_hit;
   sts_vec_t set_v;
   sts_vec_t clr_v;

   always_comb begin
      set_v           = '0;
      set_v[IDX_XFER] = ev_ioc_done | ev_short_in | ev_err_done;
      set_v[IDX_ERR]  = ev_err_done | ev_xact_err;
   end

   assign clr_v = sts_clr_we ? sts_clr_mask : '0;

   irq_thr_timer #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_timer (
      .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick),
      .thr_sel(thr_sel), .thr_hit(thr_hit)
   );

   for (genvar i = 0; i < STS_N; i++) begin : g_sts
      irq_sts_bit u_bit (
         .clk(clk), .rst_n(rst_n), .set_i(set_v[i]),
         .clr_i(clr_v[i]), .q_o(irq_sts[i])
      );
   end

   irq_out_gate u_gate (
      .clk(clk), .rst_n(rst_n), .thr_hit(thr_hit),
      .sts(irq_sts), .en(irq_en), .irq_o(irq_o)
   );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       uf_tick,
   input logic       thr_hit,
   input logic       ev_ioc_done,
   input logic       ev_short_in,
   input logic       ev_err_done,
   input logic       ev_xact_err,
   input logic [1:0] irq_en,
   input logic       sts_clr_we,
   input logic [1:0] sts_clr_mask,
   input logic [1:0] irq_sts,
   input logic       irq_o
);
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_sts == 2'b00) && !irq_o);

   assert_ioc_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ioc_done |=> irq_sts[0]);

   assert_short_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_short_in |=> irq_sts[0]);

   assert_err_sets_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err_done |=> (irq_sts == 2'b11));

   assert_xact_err_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_xact_err |=> irq_sts[1]);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sts[0] && !(sts_clr_we && sts_clr_mask[0]) |=> irq_sts[0]);

   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr_we && sts_clr_mask[1] && !ev_err_done && !ev_xact_err |=> !irq_sts[1]);

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr_we && sts_clr_mask[0] && ev_ioc_done |=> irq_sts[0]);

   assert_boundary_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      thr_hit |-> uf_tick);

   assert_rise_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(thr_hit));

   assert_no_enabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(irq_sts & irq_en)) |=> !irq_o);

   assert_hold_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && (|(irq_sts & irq_en)) |=> irq_o);
endmodule

bind xfer_irq_agg irq_agg_chk u_chk (
   .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .thr_hit(thr_hit),
   .ev_ioc_done(ev_ioc_done), .ev_short_in(ev_short_in),
   .ev_err_done(ev_err_done), .ev_xact_err(ev_xact_err),
   .irq_en(irq_en), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
   .irq_sts(irq_sts), .irq_o(irq_o)
);

// File: tb/sim_xfer_irq_agg.sv
`timescale 1ns/100ps
module sim_xfer_irq_agg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uf_tick = 1'b0;
   logic [2:0] thr_sel = 3'd0;
   logic       ev_ioc_done = 1'b0, ev_short_in = 1'b0;
   logic       ev_err_done = 1'b0, ev_xact_err = 1'b0;
   logic [1:0] irq_en = 2'b00;
   logic       sts_clr_we = 1'b0;
   logic [1:0] sts_clr_mask = 2'b00;
   logic [1:0] irq_sts;
   logic       irq_o;

   always #2 clk = ~clk;

   xfer_irq_agg u0 (
      .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .thr_sel(thr_sel),
      .ev_ioc_done(ev_ioc_done), .ev_short_in(ev_short_in),
      .ev_err_done(ev_err_done), .ev_xact_err(ev_xact_err),
      .irq_en(irq_en), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
      .irq_sts(irq_sts), .irq_o(irq_o)
   );

   typedef struct {
      logic [1:0] sts;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;

   // bench-side expectation state
   logic [1:0] m_sts = 2'b00;
   logic       m_irq = 1'b0;
   int         m_cnt = 0;

   // monitor: one time unit after each rising edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (irq_sts !== e.sts || irq_o !== e.irq) begin
            n_bad++;
            $display("FAIL %s: sts=%b irq=%b expected sts=%b irq=%b",
                     e.tag, irq_sts, irq_o, e.sts, e.irq);
         end
      end
   end

   // driver: called at a falling edge, drives one cycle
   task automatic cyc(input logic [3:0] ev, input logic uf,
                      input logic cwe, input logic [1:0] cm, input string tag);
      logic [1:0] setv;
      logic       hit, pend;
      int         k, lim;
      exp_t       e;
      {ev_xact_err, ev_err_done, ev_short_in, ev_ioc_done} = ev;
      uf_tick = uf; sts_clr_we = cwe; sts_clr_mask = cm;
      setv[0] = ev[0] | ev[1] | ev[2];
      setv[1] = ev[2] | ev[3];
      k   = (thr_sel > 3'd6) ? 6 : int'(thr_sel);
      lim = (1 << k) - 1;
      hit = uf && (m_cnt >= lim);
      if (uf) m_cnt = hit ? 0 : m_cnt + 1;
      pend  = |(m_sts & irq_en);
      m_irq = hit ? pend : (m_irq & pend);
      for (int i = 0; i < 2; i++)
         m_sts[i] = setv[i] | (m_sts[i] & ~(cwe & cm[i]));
      e.sts = m_sts; e.irq = m_irq; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      {ev_xact_err, ev_err_done, ev_short_in, ev_ioc_done} = 4'b0;
      uf_tick = 1'b0; sts_clr_we = 1'b0; sts_clr_mask = 2'b00;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(4'b0, 1'b0, 1'b0, 2'b00, tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         cyc(4'b0, 1'b1, 1'b0, 2'b00, tag);
         idle(1, tag);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(3, "R1 reset state");

      // single events, then clears
      cyc(4'b0001, 0, 0, 2'b00, "R2 ioc sets transfer flag");
      idle(2, "R6 flag sticky");
      cyc(4'b0000, 0, 1, 2'b10, "R6 zero mask bit leaves flag");
      cyc(4'b0000, 0, 1, 2'b01, "R6 clear transfer flag");
      cyc(4'b0010, 0, 0, 2'b00, "R3 short IN sets transfer flag");
      cyc(4'b0000, 0, 1, 2'b01, "R6 clear after short");
      cyc(4'b1000, 0, 0, 2'b00, "R5 xact err sets error flag only");
      cyc(4'b0000, 0, 1, 2'b10, "R6 clear error flag");
      cyc(4'b0100, 0, 0, 2'b00, "R4 error completion sets both");
      cyc(4'b0000, 0, 1, 2'b11, "R6 clear both");
      // set and clear in one cycle
      cyc(4'b0001, 0, 1, 2'b01, "R7 event beats clear");
      cyc(4'b1000, 0, 1, 2'b10, "R7 error event beats clear");
      cyc(4'b0000, 0, 1, 2'b11, "R6 clear both");

      // threshold spacing for every select, flags set and enabled
      irq_en = 2'b11;
      for (int s = 0; s < 8; s++) begin
         thr_sel = 3'(s);
         cyc(4'b0000, 0, 1, 2'b11, "R11 clear drops line");
         idle(1, "R11 line low");
         // counter realignment: run to a boundary with nothing pending
         ticks((s > 6) ? 64 : (1 << s), "R8 align");
         cyc(4'b0001, 0, 0, 2'b00, "R2 set before window");
         ticks((s > 6) ? 64 : (1 << s), "R8 R9 boundary spacing");
         idle(2, "R11 held high");
      end

      // event in the boundary cycle waits
      thr_sel = 3'd1;
      cyc(4'b0000, 0, 1, 2'b11, "R11 clear");
      ticks(2, "R8 align");
      cyc(4'b0000, 1, 0, 2'b00, "R8 count one");
      idle(1, "R9");
      cyc(4'b0001, 1, 0, 2'b00, "R9 event on boundary waits");
      idle(2, "R9 still low");
      ticks(2, "R9 next boundary raises");

      // disabled flag never raises the line
      cyc(4'b0000, 0, 0, 2'b00, "R11");
      irq_en = 2'b10;
      idle(2, "R11 disable drops line");
      ticks(6, "R10 disabled flag silent");
      cyc(4'b1000, 0, 0, 2'b00, "R5 error flag set");
      ticks(2, "R10 enabled error flag raises");
      irq_en = 2'b00;
      idle(2, "R11 disabling last drops line");
      ticks(4, "R10 all disabled");

      // reset in mid-run
      rst_n = 1'b0;
      m_sts = 2'b00; m_irq = 1'b0; m_cnt = 0;
      idle(2, "R1 reset clears");
      rst_n = 1'b1;
      idle(2, "R1 after release");

      @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule